// File: doc/BRIEF.md
# Buffered Palette with Write Queue

This block holds a 256-entry colour lookup table that turns 8-bit pixel indices into 24-bit RGB values. Software updates palette entries by presenting an index and a colour word. The update does not go into the table at once. It waits in a 64-deep queue, and the queue empties into the table only when the display side is not using the table's single lookup port.

Software can read the queue's fill level at any time. Before each write it must check the stall indication, which is raised at a fixed threshold. A write that still arrives while the queue is completely full is discarded, and a sticky overflow flag records that it happened. The lookup port always takes priority over the queue, except during blanking, when the queue also empties while lookups are running.

Top module: `pal_wbuf`

## Requirements
- R1: After a synchronous active-low reset, the fill level is 0, the stall and overflow outputs are low, and `lk_vld` is low. Every palette entry i holds i in each of its red, green and blue bytes.
- R2: In a write word, red sits in bits 31:24, green in bits 23:16 and blue in bits 15:8, and bits 7:0 are ignored. A lookup returns red in `lk_rgb[23:16]`, green in `[15:8]` and blue in `[7:0]`.
- R3: A lookup sampled at a clock edge with `lk_en` high drives `lk_vld` high and the entry's colour on `lk_rgb` right after that same edge. After an edge with `lk_en` low, `lk_vld` is low and `lk_rgb` keeps its previous value.
- R4: `wr_level` equals the number of accepted writes that have not yet drained. It changes by at most one per clock and never exceeds 64.
- R5: `wr_stall` is high exactly when `wr_level` is 63 or more.
- R6: A write presented while the level is 64 is dropped and does not change the level. It sets `wr_ovf`, and `wr_ovf` stays high until reset.
- R7: When the queue holds at least one entry, one entry drains per clock if `lk_en` is low or `blank` is high. While `lk_en` is high and `blank` is low, nothing drains.
- R8: Entries drain in the order they were written, so the later of two writes to the same index decides that index's final colour.
- R9: When a drain writes an entry in the same cycle that a lookup reads it, the lookup returns the old colour. A lookup in the next cycle returns the new colour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Palette write request |
| wr_idx | input | 8 | Palette index to update |
| wr_word | input | 32 | Colour word (R 31:24, G 23:16, B 15:8, low byte ignored) |
| wr_level | output | 7 | Queue fill level |
| wr_stall | output | 1 | High when the level is at or above the stall threshold (63) |
| wr_ovf | output | 1 | Sticky flag: a write was dropped because the queue was full |
| blank | input | 1 | Display blanking interval; allows draining during lookups |
| lk_en | input | 1 | Lookup request |
| lk_idx | input | 8 | Pixel index to look up |
| lk_rgb | output | 24 | Looked-up colour, one cycle after the request |
| lk_vld | output | 1 | Lookup result valid |

## Verification
Level, stall and overflow reflect a write one edge after the write is sampled. A write reaches the table one edge after its drain cycle, so a lookup at the second edge after an idle write already sees the new colour. Lookup data appears one edge after the request. The bench keeps a cycle-exact reference of the queue and the table. At each falling edge it compares every output against that reference and then advances the reference with the inputs it drives for the next rising edge, so each result is checked in exactly the cycle it becomes due.

// File: rtl/pal_pkg.sv
// Shared defaults for the buffered palette.
// Assumes: every module in the block takes its widths from these values.
package pal_pkg;
    localparam int unsigned PAL_IDX_W      = 8;   // index bits (256 entries)
    localparam int unsigned PAL_CH_W       = 8;   // bits per colour channel
    localparam int unsigned PAL_FIFO_DEPTH = 64;  // write queue depth
    localparam int unsigned PAL_STALL_LVL  = 63;  // level at which writers stall
endpackage

// File: rtl/pal_fifo.sv
// Write queue: first-in first-out store with a fill level.
// A push while full is refused and reported on 'dropped'; a pop while
// empty is ignored. Assumes: DEPTH >= 2.
module pal_fifo #(
    parameter int unsigned DEPTH = pal_pkg::PAL_FIFO_DEPTH,
    parameter int unsigned DW    = 32,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    output logic [DW-1:0]    head_data,
    output logic [LVL_W-1:0] level,
    output logic             empty,
    output logic             dropped
);
    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             full, accept, take;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Status from the current level.
    always_comb begin
        full    = (level == LVL_W'(DEPTH));
        empty   = (level == '0);
        accept  = push && !full;
        take    = pop && !empty;
        dropped = push && full;
    end

    assign head_data = mem[rd_ptr];

    // Storage: write the accepted entry at the tail.
    always_ff @(posedge clk) begin
        if (accept)
            mem[wr_ptr] <= push_data;
    end

    // Pointers and level bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (accept) wr_ptr <= bump(wr_ptr);
            if (take)   rd_ptr <= bump(rd_ptr);
            case ({accept, take})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/pal_arb.sv
// Drain arbiter: decides whether the queue head may enter the table this
// cycle. Lookups always win outside blanking. BLANK_DRAIN selects whether
// blanking also opens the table to the queue.
module pal_arb #(
    parameter bit BLANK_DRAIN = 1'b1
) (
    input  logic pending,
    input  logic lk_en,
    input  logic blank,
    output logic drain
);
    generate
        if (BLANK_DRAIN) begin : g_blank_open
            // Drain when the port is idle or the display is blanked.
            assign drain = pending && (!lk_en || blank);
        end else begin : g_idle_only
            // Drain only when the port is idle.
            assign drain = pending && !lk_en;
        end
    endgenerate
endmodule

// File: rtl/pal_ram.sv
// Palette table: one write port, one registered read port.
// A read in the same cycle as a write to the same entry returns the old
// value. Reset loads a grey ramp. Assumes: 2**IDX_W entries.
module pal_ram #(
    parameter int unsigned IDX_W = pal_pkg::PAL_IDX_W,
    parameter int unsigned CH_W  = pal_pkg::PAL_CH_W,
    localparam int unsigned ENTRIES = 1 << IDX_W,
    localparam int unsigned RGB_W   = 3 * CH_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [RGB_W-1:0] wr_rgb,
    input  logic             rd_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [RGB_W-1:0] rd_rgb,
    output logic             rd_vld
);
    logic [RGB_W-1:0] tbl [ENTRIES];

    // Table contents: grey ramp on reset, else take the drained entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++)
                tbl[i] <= {3{CH_W'(i)}};
        end else if (wr_en) begin
            tbl[wr_idx] <= wr_rgb;
        end
    end

    // Registered lookup result and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld <= 1'b0;
            rd_rgb <= '0;
        end else begin
            rd_vld <= rd_en;
            if (rd_en)
                rd_rgb <= tbl[rd_idx];
        end
    end
endmodule

// File: rtl/pal_wbuf.sv
// Buffered palette top: write queue, drain arbiter and lookup table.
// Writers should watch wr_stall; a write into a full queue is lost and
// latches wr_ovf until reset. Assumes: synchronous active-low reset.
module pal_wbuf #(
    parameter int unsigned IDX_W      = pal_pkg::PAL_IDX_W,
    parameter int unsigned CH_W       = pal_pkg::PAL_CH_W,
    parameter int unsigned FIFO_DEPTH = pal_pkg::PAL_FIFO_DEPTH,
    parameter int unsigned STALL_LVL  = pal_pkg::PAL_STALL_LVL,
    localparam int unsigned RGB_W  = 3 * CH_W,
    localparam int unsigned WORD_W = 4 * CH_W,
    localparam int unsigned ENT_W  = IDX_W + RGB_W,
    localparam int unsigned LVL_W  = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [WORD_W-1:0] wr_word,
    output logic [LVL_W-1:0]  wr_level,
    output logic              wr_stall,
    output logic              wr_ovf,
    input  logic              blank,
    input  logic              lk_en,
    input  logic [IDX_W-1:0]  lk_idx,
    output logic [RGB_W-1:0]  lk_rgb,
    output logic              lk_vld
);
    logic [ENT_W-1:0] ent_in, ent_head;
    logic             q_empty, drain, dropped;
    logic             unused_low;

    // Queue entry: index above the three colour bytes; low byte discarded.
    assign ent_in     = {wr_idx, wr_word[WORD_W-1:CH_W]};
    assign unused_low = ^wr_word[CH_W-1:0];

    pal_fifo #(.DEPTH(FIFO_DEPTH), .DW(ENT_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_data (ent_in),
        .pop       (drain),
        .head_data (ent_head),
        .level     (wr_level),
        .empty     (q_empty),
        .dropped   (dropped)
    );

    pal_arb #(.BLANK_DRAIN(1'b1)) u_arb (
        .pending (!q_empty),
        .lk_en   (lk_en),
        .blank   (blank),
        .drain   (drain)
    );

    pal_ram #(.IDX_W(IDX_W), .CH_W(CH_W)) u_ram (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (drain),
        .wr_idx (ent_head[ENT_W-1:RGB_W]),
        .wr_rgb (ent_head[RGB_W-1:0]),
        .rd_en  (lk_en),
        .rd_idx (lk_idx),
        .rd_rgb (lk_rgb),
        .rd_vld (lk_vld)
    );

    // Writer back-pressure at the fixed threshold.
    assign wr_stall = (wr_level >= LVL_W'(STALL_LVL));

    // Sticky overflow: set by a dropped write, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       wr_ovf <= 1'b0;
        else if (dropped) wr_ovf <= 1'b1;
    end
endmodule

// File: rtl/pal_wbuf_chk.sv
// Temporal checks on the buffered palette's ports, bound to pal_wbuf.
module pal_wbuf_chk #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned STALL = 63,
    parameter int unsigned LVL_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [LVL_W-1:0] wr_level,
    input logic             wr_stall,
    input logic             wr_ovf,
    input logic             blank,
    input logic             lk_en,
    input logic             lk_vld
);
    assert_lookup_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_en |=> lk_vld);
    assert_no_lookup_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_en |=> !lk_vld);
    assert_level_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (wr_level <= $past(wr_level) + 1) && ($past(wr_level) <= wr_level + 1));
    assert_level_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_level <= LVL_W'(DEPTH));
    assert_stall_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_stall) |-> $past(wr_en) && wr_level == LVL_W'(STALL));
    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ovf |=> wr_ovf);
    assert_ovf_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_ovf) |-> $past(wr_en) && $past(wr_level) == LVL_W'(DEPTH));
    assert_no_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_en && !blank) |=> wr_level >= $past(wr_level));
endmodule

bind pal_wbuf pal_wbuf_chk #(.DEPTH(FIFO_DEPTH), .STALL(STALL_LVL), .LVL_W(LVL_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_level (wr_level),
    .wr_stall (wr_stall),
    .wr_ovf   (wr_ovf),
    .blank    (blank),
    .lk_en    (lk_en),
    .lk_vld   (lk_vld)
);

// File: tb/sim_pal_wbuf.sv
`timescale 1ns/1ps
module sim_pal_wbuf;
    logic        clk = 1'b0;
    logic        rst_n, wr_en, blank, lk_en;
    logic [7:0]  wr_idx, lk_idx;
    logic [31:0] wr_word;
    logic [6:0]  wr_level;
    logic        wr_stall, wr_ovf, lk_vld;
    logic [23:0] lk_rgb;

    always #10 clk = ~clk;   // 50 MHz

    pal_wbuf u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
                 .wr_word(wr_word), .wr_level(wr_level), .wr_stall(wr_stall),
                 .wr_ovf(wr_ovf), .blank(blank), .lk_en(lk_en), .lk_idx(lk_idx),
                 .lk_rgb(lk_rgb), .lk_vld(lk_vld));

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // Reference state
    logic [23:0] m_pal [256];
    logic [7:0]  q_idx [64];
    logic [23:0] q_rgb [64];
    int          q_h, q_t, m_lvl;
    bit          m_ovf, m_vld;
    logic [23:0] m_rgb;
    string       tag_rgb = "R1", tag_lvl = "R4";

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(tag_lvl, "level", 32'(wr_level), 32'(m_lvl));
        chk("R5", "stall", 32'(wr_stall), 32'(m_lvl >= 63));
        chk("R6", "ovf", 32'(wr_ovf), 32'(m_ovf));
        chk("R3", "lk_vld", 32'(lk_vld), 32'(m_vld));
        if (m_vld) chk(tag_rgb, "lk_rgb", 32'(lk_rgb), 32'(m_rgb));
    endtask

    // Advance the reference by one rising edge with the given inputs.
    function automatic void step(bit w, logic [7:0] wi, logic [31:0] wd,
                                 bit l, logic [7:0] li, bit b);
        bit drain = (m_lvl > 0) && (!l || b);
        bit acc   = w && (m_lvl < 64);
        m_vld = l;
        if (l) m_rgb = m_pal[li];
        if (drain) begin
            m_pal[q_idx[q_h]] = q_rgb[q_h];
            q_h = (q_h + 1) % 64;
        end
        if (acc) begin
            q_idx[q_t] = wi;
            q_rgb[q_t] = wd[31:8];
            q_t = (q_t + 1) % 64;
        end
        if (w && !acc) m_ovf = 1'b1;
        m_lvl = m_lvl + int'(acc) - int'(drain);
    endfunction

    task automatic cyc(bit w, logic [7:0] wi, logic [31:0] wd,
                       bit l, logic [7:0] li, bit b);
        @(negedge clk);
        compare();
        step(w, wi, wd, l, li, b);
        wr_en = w; wr_idx = wi; wr_word = wd;
        lk_en = l; lk_idx = li; blank = b;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 8'h0, 32'h0, 0, 8'h0, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0; wr_en = 0; wr_idx = 0; wr_word = 0;
        lk_en = 0; lk_idx = 0; blank = 0;
        for (int i = 0; i < 256; i++) m_pal[i] = {3{8'(i)}};
        q_h = 0; q_t = 0; m_lvl = 0; m_ovf = 0; m_vld = 0; m_rgb = 24'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1", "level after reset", 32'(wr_level), 32'h0);
        chk("R1", "ovf after reset", 32'(wr_ovf), 32'h0);
        chk("R1", "stall after reset", 32'(wr_stall), 32'h0);
        chk("R1", "lk_vld after reset", 32'(lk_vld), 32'h0);
        // R1: grey ramp sweep
        tag_rgb = "R1";
        for (int i = 0; i < 256; i++) cyc(0, 8'h0, 32'h0, 1, 8'(i), 0);
        idle(2);

        // R2: field packing, low byte ignored
        tag_rgb = "R2";
        cyc(1, 8'd5, 32'hA1B2C3FF, 0, 8'h0, 0);
        idle(1);
        cyc(0, 8'h0, 32'h0, 1, 8'd5, 0);
        cyc(1, 8'd6, 32'h0102035A, 0, 8'h0, 0);
        idle(1);
        cyc(0, 8'h0, 32'h0, 1, 8'd6, 0);
        idle(2);

        // R7: no drain under active lookups, drain during blanking
        tag_lvl = "R7";
        for (int i = 0; i < 10; i++) cyc(1, 8'(40 + i), $urandom, 1, 8'(i), 0);
        for (int i = 0; i < 12; i++) cyc(0, 8'h0, 32'h0, 1, 8'(40 + i), 1);
        idle(2);

        // R6 / R5: fill past full while lookups block draining
        tag_lvl = "R6";
        for (int i = 0; i < 70; i++) cyc(1, 8'(100 + i), $urandom, 1, 8'h0, 0);
        idle(70);

        // R8: later write to the same index wins
        tag_rgb = "R8"; tag_lvl = "R4";
        cyc(1, 8'd9, 32'h11111100, 1, 8'h0, 0);
        cyc(1, 8'd9, 32'h22222200, 1, 8'h0, 0);
        idle(3);
        cyc(0, 8'h0, 32'h0, 1, 8'd9, 0);
        idle(1);

        // R9: drain and lookup of the same entry in one cycle
        tag_rgb = "R9";
        cyc(1, 8'd20, 32'h5A6B7C00, 1, 8'd20, 0);
        cyc(0, 8'h0, 32'h0, 1, 8'd20, 1);
        cyc(0, 8'h0, 32'h0, 1, 8'd20, 0);
        idle(2);

        // R4: constrained random traffic
        tag_rgb = "R4";
        for (int i = 0; i < 4000; i++) begin
            bit w = ($urandom % 2) == 0;
            bit l = ($urandom % 3) != 0;
            bit b = ($urandom % 4) == 0;
            cyc(w, 8'($urandom % 16), $urandom, l, 8'($urandom % 16), b);
        end
        idle(70);
        for (int i = 0; i < 16; i++) cyc(0, 8'h0, 32'h0, 1, 8'(i), 0);
        idle(2);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule